// File: doc/BRIEF.md
# RSSI Level Monitor with Hysteresis

This block supervises received signal strength once a tuning operation has settled. When the tuner reports that a search, a preset recall or an alternate-frequency update has finished, the monitor captures a hysteresis threshold. The threshold comes from an eight-entry table, addressed by a two-bit threshold select and a width bit that picks the narrow or the wide hysteresis column. From then on it compares the digitized level against that threshold once per slow tick, nominally every 500 µs. A level below the threshold sets a sticky flag. An interrupt request follows the flag only while the mask input is high.

A search or preset finished with threshold select 3 leaves a zero threshold, so the flag cannot set until the next tuning. A read of the flag register clears the flag. So does the start of a new tuning operation, which also suspends comparison until the next completion strobe. If a read and a setting comparison land in the same cycle, the set wins.

The controller has four states. IDLE is the state after reset, with no comparison. TUNING runs between a tune start and its completion. ARMED compares on every tick. MUTED is armed with a zero threshold. The transitions are:
- START: any state goes to TUNING on `tune_start`.
- ARM: any state goes to ARMED on a completion strobe without muting.
- MUTE: any state goes to MUTED on a search or preset completion with select 3.
- `tune_start` takes precedence over a completion strobe in the same cycle.

Top module: `rssi_hyst_monitor`

## Requirements
- R1: After reset `lev_flag` and `irq` are 0 and the block is idle: no comparison takes place, even with a level of 0, until a completion strobe arrives.
- R2: Any of `search_done`, `preset_done` or `af_done` arms the monitor and captures the threshold at that cycle. Later changes to `thr_sel` or `hyst_wide` have no effect until the next completion.
- R3: Comparison happens only on the tick. The tick counter restarts at a completion, so the first comparison is sampled exactly TICK_DIV cycles after the completion edge. The flag sets only when the level is strictly below the threshold; an equal level does not set it.
- R4: The table index is {hyst_wide, thr_sel} (hyst_wide is bit 2). The default entries for index 0..7 are 10, 20, 30, 40, 16, 28, 40 and 52.
- R5: A search or preset completed with `thr_sel` = 3 sets the threshold to 0, and the flag never sets, not even for a level of 0.
- R6: An alternate-frequency completion with `thr_sel` = 3 is not muted and uses the table entry.
- R7: Once set, the flag stays set after the level recovers.
- R8: A pulse on `stat_rd` clears the flag. When a setting comparison falls in the same cycle as `stat_rd`, the flag is set.
- R9: `tune_start` clears the flag at once and suspends comparison until the next completion strobe.
- R10: `irq` is high exactly when the flag is set and `lev_mask` is 1. The flag is set regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rssi_lvl | input | LVL_W | Digitized signal-strength level |
| thr_sel | input | 2 | Threshold select field |
| hyst_wide | input | 1 | Hysteresis column: 0 narrow, 1 wide |
| search_done | input | 1 | Search completion strobe |
| preset_done | input | 1 | Preset completion strobe |
| af_done | input | 1 | Alternate-frequency update completion strobe |
| tune_start | input | 1 | Tuning start strobe |
| stat_rd | input | 1 | Flag register read strobe |
| lev_mask | input | 1 | Interrupt mask for the level flag |
| lev_flag | output | 1 | Sticky low-level flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the monitor with TICK_DIV = 8 and keeps the default 8-bit table. The short tick lets it pin down the exact comparison edge after arming. It also makes it practical to drive a register read into the very cycle of a tick, which exercises the set-over-clear priority. With the default table, both hysteresis columns and the muted select-3 case can be checked against known threshold values.

// File: rtl/rssi_mon_pkg.sv
package rssi_mon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TUNING = 2'd1,
        ST_ARMED  = 2'd2,
        ST_MUTED  = 2'd3
    } mon_state_t;

    localparam int unsigned SEL_W   = 2;
    localparam int unsigned IDX_W   = SEL_W + 1;
    localparam int unsigned NUM_ENT = 1 << IDX_W;

endpackage

// File: rtl/rssi_tick_gen.sv
module rssi_tick_gen #(
    parameter int unsigned TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    generate
        if (TICK_DIV > 1) begin : g_chk
            AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick); // R3
        end
    endgenerate

endmodule

// File: rtl/rssi_thresh_sel.sv
module rssi_thresh_sel
    import rssi_mon_pkg::*;
#(
    parameter int unsigned LVL_W = 8,
    parameter logic [NUM_ENT*LVL_W-1:0] THR_TABLE = 64'h3428_1C10_281E_140A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             mute,
    input  logic [IDX_W-1:0] idx,
    output logic [LVL_W-1:0] thr
);
    logic [LVL_W-1:0] tbl [NUM_ENT];

    generate
        for (genvar g = 0; g < NUM_ENT; g++) begin : g_tbl
            assign tbl[g] = THR_TABLE[g*LVL_W +: LVL_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= '0;
        end else if (load) begin
            thr <= mute ? '0 : tbl[idx];
        end
    end

endmodule

// File: rtl/rssi_mon_fsm.sv
module rssi_mon_fsm
    import rssi_mon_pkg::*;
#(
    parameter int unsigned LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tune_start,
    input  logic             done_any,
    input  logic             done_mute,
    input  logic             tick,
    input  logic [LVL_W-1:0] rssi,
    input  logic [LVL_W-1:0] thr,
    input  logic             stat_rd,
    output mon_state_t       state,
    output logic             flag
);
    mon_state_t state_d;
    logic       set_now;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE, ST_TUNING, ST_ARMED, ST_MUTED: begin
                if (tune_start) begin
                    state_d = ST_TUNING;
                end else if (done_any) begin
                    state_d = done_mute ? ST_MUTED : ST_ARMED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    assign set_now = (state == ST_ARMED) && tick && !done_any && (rssi < thr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (tune_start) begin
            flag <= 1'b0;
        end else if (set_now) begin
            flag <= 1'b1;
        end else if (stat_rd) begin
            flag <= 1'b0;
        end
    end

    AST_TUNE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tune_start |=> !flag); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !tick) |=> !flag); // R8
    AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !$rose(flag)); // R3
    AST_NO_SET_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ARMED) |=> !$rose(flag)); // R5

endmodule

// File: rtl/rssi_hyst_monitor.sv
module rssi_hyst_monitor
    import rssi_mon_pkg::*;
#(
    parameter int unsigned TICK_DIV = 50000,
    parameter int unsigned LVL_W = 8,
    parameter logic [NUM_ENT*LVL_W-1:0] THR_TABLE = 64'h3428_1C10_281E_140A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rssi_lvl,
    input  logic [1:0]       thr_sel,
    input  logic             hyst_wide,
    input  logic             search_done,
    input  logic             preset_done,
    input  logic             af_done,
    input  logic             tune_start,
    input  logic             stat_rd,
    input  logic             lev_mask,
    output logic             lev_flag,
    output logic             irq
);
    logic             done_any;
    logic             done_mute;
    logic             arm;
    logic             tick;
    logic [LVL_W-1:0] thr;
    mon_state_t       state;

    assign done_any  = search_done | preset_done | af_done;
    assign done_mute = (search_done | preset_done) && (thr_sel == 2'd3);
    assign arm       = done_any && !tune_start;

    rssi_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm),
        .tick    (tick)
    );

    rssi_thresh_sel #(
        .LVL_W     (LVL_W),
        .THR_TABLE (THR_TABLE)
    ) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (arm),
        .mute  (done_mute),
        .idx   ({hyst_wide, thr_sel}),
        .thr   (thr)
    );

    rssi_mon_fsm #(
        .LVL_W (LVL_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tune_start (tune_start),
        .done_any   (done_any),
        .done_mute  (done_mute),
        .tick       (tick),
        .rssi       (rssi_lvl),
        .thr        (thr),
        .stat_rd    (stat_rd),
        .state      (state),
        .flag       (lev_flag)
    );

    assign irq = lev_flag & lev_mask;

    AST_MUTED_THR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUTED) |-> (thr == '0)); // R5

endmodule

// File: tb/rssi_hyst_monitor_tb.sv
module rssi_hyst_monitor_tb;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rssi_lvl = 8'd255;
    logic [1:0] thr_sel = 2'd0;
    logic       hyst_wide = 1'b0;
    logic       search_done = 1'b0;
    logic       preset_done = 1'b0;
    logic       af_done = 1'b0;
    logic       tune_start = 1'b0;
    logic       stat_rd = 1'b0;
    logic       lev_mask = 1'b0;
    logic       lev_flag;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rssi_hyst_monitor #(.TICK_DIV(DIV), .LVL_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .rssi_lvl(rssi_lvl), .thr_sel(thr_sel),
        .hyst_wide(hyst_wide), .search_done(search_done), .preset_done(preset_done),
        .af_done(af_done), .tune_start(tune_start), .stat_rd(stat_rd),
        .lev_mask(lev_mask), .lev_flag(lev_flag), .irq(irq)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // 0 search, 1 preset, 2 af, 3 tune start, 4 read
    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: search_done = 1'b1;
            1: preset_done = 1'b1;
            2: af_done = 1'b1;
            3: tune_start = 1'b1;
            default: stat_rd = 1'b1;
        endcase
        @(negedge clk);
        search_done = 1'b0; preset_done = 1'b0; af_done = 1'b0;
        tune_start = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check(lev_flag, 1'b0, "R1", "flag after reset");
        check(irq, 1'b0, "R1", "irq after reset");
        rssi_lvl = 8'd0;
        wait_cyc(3*DIV);
        check(lev_flag, 1'b0, "R1", "idle no compare");
    endtask

    task automatic t_arm_timing;
        thr_sel = 2'd1; hyst_wide = 1'b0; rssi_lvl = 8'd19; lev_mask = 1'b0;
        strobe(0);
        wait_cyc(DIV-1);
        check(lev_flag, 1'b0, "R3", "before first tick");
        wait_cyc(1);
        check(lev_flag, 1'b1, "R3", "on first tick below 20");
        check(irq, 1'b0, "R10", "masked irq");
        lev_mask = 1'b1;
        #1;
        check(irq, 1'b1, "R10", "unmasked irq");
        rssi_lvl = 8'd200;
        wait_cyc(2*DIV);
        check(lev_flag, 1'b1, "R7", "sticky after recovery");
        strobe(4);
        check(lev_flag, 1'b0, "R8", "read clears");
        wait_cyc(2*DIV);
        check(lev_flag, 1'b0, "R8", "stays clear");
        lev_mask = 1'b0;
    endtask

    task automatic t_columns;
        strobe(3);
        thr_sel = 2'd2; hyst_wide = 1'b1; rssi_lvl = 8'd40;
        strobe(2);
        wait_cyc(3*DIV);
        check(lev_flag, 1'b0, "R3", "equal level does not set");
        rssi_lvl = 8'd39;
        wait_cyc(2*DIV);
        check(lev_flag, 1'b1, "R4", "wide column idx6 = 40");
        strobe(3);
        thr_sel = 2'd2; hyst_wide = 1'b0; rssi_lvl = 8'd35;
        strobe(1);
        wait_cyc(3*DIV);
        check(lev_flag, 1'b0, "R4", "narrow idx2 = 30 vs 35");
        strobe(3);
        hyst_wide = 1'b1;
        strobe(1);
        wait_cyc(3*DIV);
        check(lev_flag, 1'b1, "R4", "wide idx6 = 40 vs 35");
    endtask

    task automatic t_latch;
        strobe(3);
        thr_sel = 2'd0; hyst_wide = 1'b0; rssi_lvl = 8'd15;
        strobe(0);
        thr_sel = 2'd3; hyst_wide = 1'b1;
        wait_cyc(3*DIV);
        check(lev_flag, 1'b0, "R2", "later select change ignored");
    endtask

    task automatic t_mute;
        strobe(3);
        thr_sel = 2'd3; hyst_wide = 1'b0; rssi_lvl = 8'd0; lev_mask = 1'b1;
        strobe(0);
        wait_cyc(3*DIV);
        check(lev_flag, 1'b0, "R5", "search sel3 muted");
        strobe(1);
        wait_cyc(3*DIV);
        check(lev_flag, 1'b0, "R5", "preset sel3 muted");
        check(irq, 1'b0, "R5", "no irq when muted");
        lev_mask = 1'b0;
    endtask

    task automatic t_af_sel3;
        strobe(3);
        thr_sel = 2'd3; hyst_wide = 1'b0; rssi_lvl = 8'd0;
        strobe(2);
        wait_cyc(2*DIV);
        check(lev_flag, 1'b1, "R6", "af sel3 uses table");
    endtask

    task automatic t_tune_clears;
        check(lev_flag, 1'b1, "R9", "flag set before tune");
        strobe(3);
        check(lev_flag, 1'b0, "R9", "tune start clears");
        wait_cyc(3*DIV);
        check(lev_flag, 1'b0, "R9", "no compare while tuning");
    endtask

    task automatic t_rd_priority;
        thr_sel = 2'd1; hyst_wide = 1'b0; rssi_lvl = 8'd5;
        strobe(0);
        wait_cyc(DIV-1);
        stat_rd = 1'b1;
        wait_cyc(1);
        stat_rd = 1'b0;
        check(lev_flag, 1'b1, "R8", "set beats same-cycle read");
        rssi_lvl = 8'd200;
        strobe(4);
        check(lev_flag, 1'b0, "R8", "read clears later");
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_arm_timing();
        t_columns();
        t_latch();
        t_mute();
        t_af_sel3();
        t_tune_clears();
        t_rd_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule